// File: doc/BRIEF.md
# Auto-Reloading Interval Timer

This block is an 8-bit interval timer for a small control processor. An up-counter advances once on every cycle in which the oscillator tick enable is high. When it steps past its all-ones value it does not wrap to zero. It reloads from a processor-written reload register and emits a one-cycle overflow pulse. That pulse sets a sticky pending flag, and the flag drives an interrupt request through a local mask bit and a chip-level global enable. The raw overflow pulse is also exported on its own, so that wake-up logic can use it.

The processor reaches the timer through a simple strobe bus with a two-bit address. Writing the counter address never loads the written byte into the counter. The counter presets from the reload register instead, and this is how software starts or restarts a period. Reads are registered. The selected value is captured at the read strobe and held until the next read. A counter read therefore always returns one consistent snapshot, even if the counter ticks during the access.

Top module: `reload_timer`

## Requirements
- R1: While and after reset, with no bus access yet made, irqOut, ovfPulse and busRdData are all 0. The counter, the reload register, the pending flag and the mask bit read back as 0.
- R2: A write to address 0 stores busWrData in the reload register. A read of address 0 returns that value.
- R3: The counter advances by one on each cycle with tickEn high. It holds its value on cycles with tickEn low.
- R4: A tick while the counter holds FFh loads the reload value, not 00h. With reload FAh, the counter runs FA, FB, FC, FD, FE, FF, FA. With reload FFh, every tick is an overflow.
- R5: A write to address 1 discards busWrData and presets the counter from the reload register. This preset takes priority over a tick in the same cycle, and no overflow occurs in that cycle.
- R6: ovfPulse is high for exactly the one cycle that follows each clock edge at which an overflow tick was taken. During that cycle the counter already holds the reload value.
- R7: The pending flag is set by each overflow. It stays set until a write to address 2 with data bit 0 equal to 1. A write with bit 0 equal to 0 leaves the flag unchanged. If an overflow and a clearing write fall on the same edge, the flag ends up set.
- R8: irqOut is high exactly when the pending flag, the mask bit and globalIntEn are all 1.
- R9: A read strobe (busRdEn) captures, at its clock edge, the value the selected register held before that edge. busRdData shows the capture from the next cycle onward and holds it until the next read strobe.
- R10: Address 2 reads back the pending flag in bit 0 and the mask bit in bit 1, with the other bits 0. A write to address 2 sets the mask from data bit 1. Address 3 reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle count enable from the oscillator domain |
| globalIntEn | input | 1 | Chip-level interrupt enable |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 2 | Register address: 0 reload, 1 counter, 2 control/status, 3 unused |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Registered read data |
| irqOut | output | 1 | Gated interrupt request |
| ovfPulse | output | 1 | One-cycle overflow pulse, for wake-up logic |

## Verification
A directed run with reload FAh and a tick on every cycle reads the counter each cycle. It shows whether the wrap goes to the reload value or to zero, and whether the pulse lands in the cycle after FFh. Reload FFh with ticks on every cycle checks for back-to-back overflows. Counter writes with junk data, some of them coinciding with a tick at FFh, separate preset-by-reload from a plain data load, and show whether the preset wins over the tick. Constrained random traffic then mixes sparse and dense ticks, random addresses, overlapping reads and writes, random reload values and a toggling global enable. All of it is compared against a reference model, which exposes ordering slips between the read capture, the pending flag and the interrupt gating.

// File: rtl/timer_pkg.sv
package timer_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;

  typedef enum logic [1:0] {
    RD_RELOAD = 2'd0,
    RD_COUNT  = 2'd1,
    RD_CTRL   = 2'd2,
    RD_NONE   = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   presetCnt;
    logic   wrReload;
    logic   wrCtrl;
    logic   rdStrobe;
    rdSel_e rdSel;
  } tmrStrobes_t;

endpackage

// File: rtl/timer_control.sv
module timer_control
  import timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        ctrlBits,
  input  logic              wrapEvt,
  input  logic              globalIntEn,
  output tmrStrobes_t       strb,
  output logic              pendBit,
  output logic              maskBit,
  output logic              irqOut,
  output logic [CNT_W-1:0]  statusByte
);

  localparam int PAD_W = CNT_W - 2;

  logic pendQ;
  logic maskQ;
  logic clrReq;

  // Address decode into datapath strobes
  always_comb begin
    strb           = '0;
    strb.presetCnt = busWrEn && (busAddr == ADDR_COUNT);
    strb.wrReload  = busWrEn && (busAddr == ADDR_RELOAD);
    strb.wrCtrl    = busWrEn && (busAddr == ADDR_CTRL);
    strb.rdStrobe  = busRdEn;
    case (busAddr)
      ADDR_RELOAD: strb.rdSel = RD_RELOAD;
      ADDR_COUNT:  strb.rdSel = RD_COUNT;
      ADDR_CTRL:   strb.rdSel = RD_CTRL;
      default:     strb.rdSel = RD_NONE;
    endcase
  end

  assign clrReq = strb.wrCtrl && ctrlBits[0];

  // Sticky pending flag: a new overflow wins over a clear on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else if (wrapEvt) begin
      pendQ <= 1'b1;
    end else if (clrReq) begin
      pendQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= 1'b0;
    end else if (strb.wrCtrl) begin
      maskQ <= ctrlBits[1];
    end
  end

  assign pendBit    = pendQ;
  assign maskBit    = maskQ;
  assign irqOut     = pendQ && maskQ && globalIntEn;
  assign statusByte = {{PAD_W{1'b0}}, maskQ, pendQ};

endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  tmrStrobes_t      strb,
  input  logic [CNT_W-1:0] wrData,
  input  logic [CNT_W-1:0] statusByte,
  output logic             wrapEvt,
  output logic             ovfPulse,
  output logic [CNT_W-1:0] rdData
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] relQ;
  logic [CNT_W-1:0] rdQ;
  logic [CNT_W-1:0] rdMux;
  logic             atMax;
  logic             ovfQ;

  assign atMax   = &cntQ;
  assign wrapEvt = tickEn && atMax && !strb.presetCnt;

  // A preset beats a tick; an overflow tick reloads instead of wrapping to zero
  always_comb begin
    cntNext = cntQ;
    if (strb.presetCnt) begin
      cntNext = relQ;
    end else if (tickEn) begin
      cntNext = atMax ? relQ : (cntQ + CNT_ONE);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else begin
      cntQ <= cntNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relQ <= '0;
    end else if (strb.wrReload) begin
      relQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfQ <= 1'b0;
    end else begin
      ovfQ <= wrapEvt;
    end
  end

  always_comb begin
    case (strb.rdSel)
      RD_RELOAD: rdMux = relQ;
      RD_COUNT:  rdMux = cntQ;
      RD_CTRL:   rdMux = statusByte;
      default:   rdMux = '0;
    endcase
  end

  // Snapshot at the strobe so a multi-cycle read never sees a moving value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (strb.rdStrobe) begin
      rdQ <= rdMux;
    end
  end

  assign ovfPulse = ovfQ;
  assign rdData   = rdQ;

endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              globalIntEn,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [CNT_W-1:0]  busRdData,
  output logic              irqOut,
  output logic              ovfPulse
);

  tmrStrobes_t      strb;
  logic             wrapEvt;
  logic             pendBit;
  logic             maskBit;
  logic [CNT_W-1:0] statusByte;

  timer_control #(.CNT_W(CNT_W)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busAddr    (busAddr),
    .ctrlBits   (busWrData[1:0]),
    .wrapEvt    (wrapEvt),
    .globalIntEn(globalIntEn),
    .strb       (strb),
    .pendBit    (pendBit),
    .maskBit    (maskBit),
    .irqOut     (irqOut),
    .statusByte (statusByte)
  );

  timer_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .strb      (strb),
    .wrData    (busWrData),
    .statusByte(statusByte),
    .wrapEvt   (wrapEvt),
    .ovfPulse  (ovfPulse),
    .rdData    (busRdData)
  );

endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk
  import timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              globalIntEn,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              clrBit,
  input logic [CNT_W-1:0]  busRdData,
  input logic              irqOut,
  input logic              ovfPulse,
  input logic              pendBit,
  input logic              maskBit
);

  // R3
  ovf_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> $past(tickEn));

  // R5
  preset_blocks_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(busWrEn && busAddr == ADDR_COUNT) |-> !ovfPulse);

  // R7
  ovf_sets_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> pendBit);

  // R7
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendBit && !(busWrEn && busAddr == ADDR_CTRL && clrBit)) |=> pendBit);

  // R8
  irq_gating_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (pendBit && maskBit && globalIntEn));

  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendBit && maskBit && globalIntEn) |-> irqOut);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> $stable(busRdData));

endmodule

bind reload_timer reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .tickEn     (tickEn),
  .globalIntEn(globalIntEn),
  .busWrEn    (busWrEn),
  .busRdEn    (busRdEn),
  .busAddr    (busAddr),
  .clrBit     (busWrData[0]),
  .busRdData  (busRdData),
  .irqOut     (irqOut),
  .ovfPulse   (ovfPulse),
  .pendBit    (pendBit),
  .maskBit    (maskBit)
);

// File: tb/sim_reload_timer.sv
module sim_reload_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       globalIntEn = 1'b0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWrData = 8'd0;
  logic [7:0] busRdData;
  logic       irqOut;
  logic       ovfPulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  logic [7:0] mCnt = 8'd0, mRel = 8'd0, mRd = 8'd0;
  logic       mPend = 1'b0, mMask = 1'b0, mOvf = 1'b0;

  always #2 clk = ~clk;

  reload_timer u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .globalIntEn(globalIntEn),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut),
    .ovfPulse(ovfPulse)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] readVal(input logic [1:0] a);
    case (a)
      2'd0:    return mRel;
      2'd1:    return mCnt;
      2'd2:    return {6'd0, mMask, mPend};
      default: return 8'd0;
    endcase
  endfunction

  // one bus cycle: drive, clock, update model, compare
  task automatic cyc(input bit wr, input bit rd, input logic [1:0] a,
                     input logic [7:0] d, input bit tk, input string tag);
    logic [7:0] nCnt, nRel, nRd;
    logic       nPend, nMask, nOvf;
    @(negedge clk);
    busWrEn = wr; busRdEn = rd; busAddr = a; busWrData = d; tickEn = tk;
    @(posedge clk);
    nCnt = mCnt; nRel = mRel; nRd = mRd; nPend = mPend; nMask = mMask; nOvf = 1'b0;
    if (wr && a == 2'd1) nCnt = mRel;
    else if (tk) begin
      if (mCnt == 8'hFF) begin nCnt = mRel; nOvf = 1'b1; end
      else nCnt = mCnt + 8'd1;
    end
    if (rd) nRd = readVal(a);
    if (wr && a == 2'd0) nRel = d;
    if (wr && a == 2'd2) begin
      nMask = d[1];
      if (d[0]) nPend = 1'b0;
    end
    if (nOvf) nPend = 1'b1;
    mCnt = nCnt; mRel = nRel; mRd = nRd; mPend = nPend; mMask = nMask; mOvf = nOvf;
    #1;
    chk({tag, " R9 rdData"}, busRdData, mRd);
    chk({tag, " R6 ovfPulse"}, {7'd0, ovfPulse}, {7'd0, mOvf});
    chk({tag, " R8 irqOut"}, {7'd0, irqOut}, {7'd0, mPend & mMask & globalIntEn});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    // R1: outputs during reset
    #7;
    chk("R1 rdData in reset", busRdData, 8'd0);
    chk("R1 irq in reset", {7'd0, irqOut}, 8'd0);
    chk("R1 ovf in reset", {7'd0, ovfPulse}, 8'd0);
    @(negedge clk); rstN = 1'b1;
    cyc(0, 1, 2'd0, 8'h00, 0, "R1 reload");
    chk("R1 reload value", busRdData, 8'h00);
    cyc(0, 1, 2'd1, 8'h00, 0, "R1 count");
    chk("R1 count value", busRdData, 8'h00);
    cyc(0, 1, 2'd2, 8'h00, 0, "R1 status");
    chk("R1 status value", busRdData, 8'h00);

    // R2 reload write/read
    cyc(1, 0, 2'd0, 8'hFA, 0, "R2 wr");
    cyc(0, 1, 2'd0, 8'h00, 0, "R2 rd");
    chk("R2 reload readback", busRdData, 8'hFA);

    // R5 counter write discards data
    cyc(1, 0, 2'd1, 8'h33, 0, "R5 preset");
    cyc(0, 1, 2'd1, 8'h00, 0, "R5 rd");
    chk("R5 preset from reload", busRdData, 8'hFA);

    // R3 hold without tick
    cyc(0, 1, 2'd1, 8'h00, 0, "R3 hold");
    chk("R3 hold", busRdData, 8'hFA);

    // R4 sequence FA..FF,FA with tick every cycle; read captures pre-edge value
    for (int k = 0; k < 8; k++) begin
      cyc(0, 1, 2'd1, 8'h00, 1, "R4 seq");
      chk("R4 sequence", busRdData, (k < 6) ? 8'(8'hFA + k) : 8'(8'hFA + k - 6));
    end

    // R7/R10 pending visible, write 0 leaves it
    cyc(0, 1, 2'd2, 8'h00, 0, "R10 st");
    chk("R10 pending bit", busRdData, 8'h01);
    cyc(1, 0, 2'd2, 8'h02, 0, "R7 w0");
    cyc(0, 1, 2'd2, 8'h00, 0, "R7 st");
    chk("R7 no clear by 0", busRdData, 8'h03);
    // R8 gating
    @(negedge clk); globalIntEn = 1'b1;
    #1 chk("R8 irq all set", {7'd0, irqOut}, 8'd1);
    @(negedge clk); globalIntEn = 1'b0;
    #1 chk("R8 irq gie low", {7'd0, irqOut}, 8'd0);
    globalIntEn = 1'b1;
    cyc(1, 0, 2'd2, 8'h03, 0, "R7 w1c");
    chk("R7 cleared irq", {7'd0, irqOut}, 8'd0);

    // R5 preset wins over tick at FF
    cyc(1, 0, 2'd0, 8'hFF, 0, "R4 relFF");
    cyc(1, 0, 2'd1, 8'h00, 0, "R4 preset");
    cyc(1, 0, 2'd1, 8'h77, 1, "R5 preset+tick");
    chk("R5 no overflow on preset", {7'd0, ovfPulse}, 8'd0);
    // R4 reload FF: back-to-back overflows
    for (int k = 0; k < 4; k++) begin
      cyc(0, 0, 2'd0, 8'h00, 1, "R4 ffwrap");
      chk("R4 back-to-back ovf", {7'd0, ovfPulse}, 8'd1);
    end
    // R7 overflow and clear on same edge: set wins
    cyc(1, 0, 2'd2, 8'h03, 1, "R7 race");
    cyc(0, 1, 2'd2, 8'h00, 0, "R7 race rd");
    chk("R7 set wins", busRdData, 8'h03);

    // R10 address 3
    cyc(1, 1, 2'd3, 8'hFF, 0, "R10 a3");
    chk("R10 addr3 reads 0", busRdData, 8'h00);
    cyc(0, 1, 2'd0, 8'h00, 0, "R10 a3 rel");
    chk("R10 addr3 write no effect", busRdData, 8'hFF);

    // random traffic (R3 counting etc.)
    for (int i = 0; i < 4000; i++) begin
      bit wr, rd, tk;
      logic [1:0] a;
      logic [7:0] d;
      wr = ($urandom % 100) < 12;
      rd = ($urandom % 100) < 40;
      tk = ($urandom % 100) < ((i / 1000) % 2 == 0 ? 90 : 30);
      a  = 2'($urandom % 4);
      d  = 8'($urandom);
      if (a == 2'd0 && wr) d = d | 8'hE0;
      if (($urandom % 50) == 0) globalIntEn = ~globalIntEn;
      cyc(wr, rd, a, d, tk, "R3 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule